// File: doc/BRIEF.md
# 64-bit User Counter Bank

This block keeps three free-running 64-bit counters for a processor core: elapsed clock cycles, real-time ticks and retired instructions. Software reaches them through a CSR-style port addressed by 12-bit register numbers. A read request returns data one cycle later, and a write request overwrites a counter or half of one. With a 32-bit data path every counter appears as two 32-bit halves at separate addresses. With a 64-bit data path one address returns the whole value and the high-half addresses are rejected.

The block fixes the ordering inside a single cycle. A read captures the counter as it stood before the edge, so an instruction that reads the retired counter while it retires sees the value from before its own retirement. A write is applied after that cycle's own increment, so the written value is what the next instruction reads. A 32-bit reader gets a consistent 64-bit value by reading high, low, then high again, and retrying when the two high reads differ. The real-time tick pulse is expected to be synchronous to the clock and to arrive at a constant period.

Top module: `ucnt_bank`

## Requirements
- R1: A synchronous active-high reset clears all three counters, `csr_rdata` and `csr_illegal`.
- R2: The cycle counter (address 0xC00) increases by one on every clock edge that is not in reset.
- R3: The time counter (address 0xC01) increases by one only on edges where `rt_tick` is high.
- R4: The retired-instruction counter (address 0xC02) increases by one only on edges where `retire` is high.
- R5: Read data is registered. A read on one edge returns, after that edge, the counter value held before it, so a read in the same cycle as a retire sees the value from before that retire.
- R6: With XLEN=32, addresses 0xC00/0xC01/0xC02 return bits 31:0 and 0xC80/0xC81/0xC82 return bits 63:32 of the cycle, time and retired counters. A write to one of these addresses replaces only that half.
- R7: With XLEN=64, addresses 0xC00..0xC02 read and write all 64 bits, and 0xC80..0xC82 are illegal.
- R8: A write is applied after the same-cycle increment: the written half holds exactly the written data, and the other half comes from the incremented value.
- R9: A read or write to an unmapped address raises `csr_illegal` on the next cycle, returns zero data and changes no counter.
- R10: A carry from bit 31 into bit 32 between the first and second high-half reads makes the two high reads differ.
- R11: When neither `csr_rd` nor `csr_wr` is asserted, the next cycle shows zero `csr_rdata` and low `csr_illegal`; a write without a read also returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rt_tick | input | 1 | One-cycle real-time tick pulse |
| retire | input | 1 | One-cycle instruction-retired pulse |
| csr_rd | input | 1 | Read request |
| csr_wr | input | 1 | Write request |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, valid the cycle after the request |
| csr_illegal | output | 1 | Address rejected, valid the cycle after the request |

## Verification
Both outputs are due exactly one edge after the request. The bench drives each request just after a falling edge, lets one rising edge pass and compares at the next falling edge. Counter updates are due on that same rising edge, so the reference model advances every counter once per step before the next request reads them. For this reason the expected value of a read is taken from the model before the step and compared after it.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    localparam int CNT_W = 64;

    localparam logic [11:0] A_CYC_LO  = 12'hC00;
    localparam logic [11:0] A_TIME_LO = 12'hC01;
    localparam logic [11:0] A_INST_LO = 12'hC02;
    localparam logic [11:0] A_CYC_HI  = 12'hC80;
    localparam logic [11:0] A_TIME_HI = 12'hC81;
    localparam logic [11:0] A_INST_HI = 12'hC82;

    typedef enum logic [1:0] {
        SEL_CYCLE   = 2'd0,
        SEL_TIME    = 2'd1,
        SEL_INSTRET = 2'd2
    } cnt_sel_e;

    typedef struct packed {
        logic     legal;
        logic     hi;
        cnt_sel_e sel;
    } csr_dec_t;

    // Bit 7 picks the upper half; bits 1:0 pick the counter.
    function automatic csr_dec_t decode_csr(input logic [11:0] a, input logic wide);
        csr_dec_t d;
        logic     base_ok;
        base_ok = (a[11:8] == 4'hC) && (a[6:2] == 5'd0) && (a[1:0] != 2'd3);
        d.hi    = a[7];
        d.sel   = cnt_sel_e'(a[1:0]);
        d.legal = base_ok && !(wide && a[7]);
        return d;
    endfunction

endpackage

// File: rtl/ucnt_counter.sv
module ucnt_counter #(
    parameter int XLEN = 32,
    parameter int CW   = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wdata,
    output logic [CW-1:0]   value
);
    localparam int HALF = CW / 2;

    logic [CW-1:0] bumped;
    logic [CW-1:0] nxt;

    // Increment first; a write then overrides the selected part.
    assign bumped = value + {{(CW-1){1'b0}}, inc};

    generate
        if (XLEN >= CW) begin : g_full
            always_comb begin
                nxt = bumped;
                if (wr_lo || wr_hi) nxt = wdata[CW-1:0];
            end
        end else begin : g_split
            always_comb begin
                nxt = bumped;
                if (wr_lo) nxt = {bumped[CW-1:HALF], wdata[HALF-1:0]};
                if (wr_hi) nxt = {wdata[HALF-1:0], bumped[HALF-1:0]};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= nxt;
    end
endmodule

// File: rtl/ucnt_readport.sv
module ucnt_readport
    import ucnt_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd,
    input  logic            wr,
    input  csr_dec_t        dec,
    input  logic [CW-1:0]   v_cyc,
    input  logic [CW-1:0]   v_time,
    input  logic [CW-1:0]   v_inst,
    output logic [XLEN-1:0] rdata,
    output logic            illegal
);
    localparam int HALF = CW / 2;

    logic [CW-1:0]   picked;
    logic [XLEN-1:0] shaped;

    always_comb begin
        unique case (dec.sel)
            SEL_CYCLE: picked = v_cyc;
            SEL_TIME:  picked = v_time;
            default:   picked = v_inst;
        endcase
    end

    generate
        if (XLEN >= CW) begin : g_full
            assign shaped = picked[XLEN-1:0];
        end else begin : g_split
            assign shaped = dec.hi ? picked[CW-1:HALF] : picked[HALF-1:0];
        end
    endgenerate

    // Registered: captures counters as they stood before this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            illegal <= 1'b0;
        end else begin
            rdata   <= (rd && dec.legal) ? shaped : '0;
            illegal <= (rd || wr) && !dec.legal;
        end
    end
endmodule

// File: rtl/ucnt_bank.sv
module ucnt_bank
    import ucnt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rt_tick,
    input  logic            retire,
    input  logic            csr_rd,
    input  logic            csr_wr,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal
);
    localparam int  NCNT = 3;
    localparam logic WIDE = (XLEN >= CNT_W);

    csr_dec_t          dec;
    logic [NCNT-1:0]   inc_vec;
    logic [CNT_W-1:0]  val [NCNT];

    assign dec     = decode_csr(csr_addr, WIDE);
    assign inc_vec = {retire, rt_tick, 1'b1};

    generate
        for (genvar i = 0; i < NCNT; i++) begin : g_cnt
            logic hit;
            assign hit = csr_wr && dec.legal && (dec.sel == cnt_sel_e'(i));
            ucnt_counter #(.XLEN(XLEN), .CW(CNT_W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (inc_vec[i]),
                .wr_lo (hit && !dec.hi),
                .wr_hi (hit && dec.hi),
                .wdata (csr_wdata),
                .value (val[i])
            );
        end
    endgenerate

    ucnt_readport #(.XLEN(XLEN), .CW(CNT_W)) u_rport (
        .clk     (clk),
        .rst     (rst),
        .rd      (csr_rd),
        .wr      (csr_wr),
        .dec     (dec),
        .v_cyc   (val[0]),
        .v_time  (val[1]),
        .v_inst  (val[2]),
        .rdata   (csr_rdata),
        .illegal (csr_illegal)
    );
endmodule

// File: rtl/ucnt_checker.sv
module ucnt_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_rd,
    input logic            csr_wr,
    input logic [11:0]     csr_addr,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_illegal
);
    logic lo_addr, hi_addr, mapped;
    assign lo_addr = (csr_addr == 12'hC00) || (csr_addr == 12'hC01) || (csr_addr == 12'hC02);
    assign hi_addr = (csr_addr == 12'hC80) || (csr_addr == 12'hC81) || (csr_addr == 12'hC82);
    assign mapped  = lo_addr || (hi_addr && (XLEN < 64));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (csr_rdata == '0) && !csr_illegal);

    p_cycle_step_r2: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && !csr_wr && csr_addr == 12'hC00)
        ##1 (csr_rd && !csr_wr && csr_addr == 12'hC00)
        |=> csr_rdata == $past(csr_rdata) + 1'b1);

    p_hi_reject_r7: assert property (@(posedge clk) disable iff (rst)
        ((XLEN >= 64) && hi_addr && (csr_rd || csr_wr)) |=> csr_illegal);

    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        ((csr_rd || csr_wr) && !mapped) |=> csr_illegal && (csr_rdata == '0));

    p_mapped_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (mapped || !(csr_rd || csr_wr)) |=> !csr_illegal);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!csr_rd) |=> (csr_rdata == '0));
endmodule

bind ucnt_bank ucnt_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_rd      (csr_rd),
    .csr_wr      (csr_wr),
    .csr_addr    (csr_addr),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal)
);

// File: tb/ucnt_bank_tb.sv
`timescale 1ns/1ps
module ucnt_bank_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // 32-bit instance
    logic        t_a, r_a, rd_a, wr_a, il_a;
    logic [11:0] ad_a;
    logic [31:0] wd_a, rdat_a;
    // 64-bit instance
    logic        t_b, r_b, rd_b, wr_b, il_b;
    logic [11:0] ad_b;
    logic [63:0] wd_b, rdat_b;

    ucnt_bank #(.XLEN(32)) u_dut (
        .clk(clk), .rst(rst), .rt_tick(t_a), .retire(r_a), .csr_rd(rd_a),
        .csr_wr(wr_a), .csr_addr(ad_a), .csr_wdata(wd_a),
        .csr_rdata(rdat_a), .csr_illegal(il_a));

    ucnt_bank #(.XLEN(64)) u_dut64 (
        .clk(clk), .rst(rst), .rt_tick(t_b), .retire(r_b), .csr_rd(rd_b),
        .csr_wr(wr_b), .csr_addr(ad_b), .csr_wdata(wd_b),
        .csr_rdata(rdat_b), .csr_illegal(il_b));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] ma [3];
    logic [63:0] mb [3];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench map: returns counter index or -1.
    function automatic int idx_of(input logic [11:0] a, input bit wide, output bit hi);
        hi = 1'b0;
        case (a)
            12'hC00: return 0;
            12'hC01: return 1;
            12'hC02: return 2;
            12'hC80: begin hi = 1'b1; return wide ? -1 : 0; end
            12'hC81: begin hi = 1'b1; return wide ? -1 : 1; end
            12'hC82: begin hi = 1'b1; return wide ? -1 : 2; end
            default: return -1;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 3; k++) begin ma[k] = '0; mb[k] = '0; end
    endtask

    // One clock step. which=0 drives the 32-bit DUT, 1 the 64-bit DUT.
    task automatic step(input int which, input bit rd, input bit wr, input logic [11:0] a,
                        input logic [63:0] wd, input bit ret, input bit tk, input string req);
        bit hi; int ix; logic [63:0] exp_d; bit exp_il; logic [63:0] v;
        t_a = 0; r_a = 0; rd_a = 0; wr_a = 0; ad_a = '0; wd_a = '0;
        t_b = 0; r_b = 0; rd_b = 0; wr_b = 0; ad_b = '0; wd_b = '0;
        ix = idx_of(a, which == 1, hi);
        exp_il = (rd || wr) && (ix < 0);
        exp_d  = '0;
        if (which == 0) begin
            t_a = tk; r_a = ret; rd_a = rd; wr_a = wr; ad_a = a; wd_a = wd[31:0];
            if (rd && ix >= 0) exp_d = hi ? {32'h0, ma[ix][63:32]} : {32'h0, ma[ix][31:0]};
        end else begin
            t_b = tk; r_b = ret; rd_b = rd; wr_b = wr; ad_b = a; wd_b = wd;
            if (rd && ix >= 0) exp_d = mb[ix];
        end
        @(posedge clk);
        // model: increments first, then the write
        ma[0] = ma[0] + 1; mb[0] = mb[0] + 1;
        if (which == 0) begin
            ma[1] = ma[1] + 64'(tk); ma[2] = ma[2] + 64'(ret);
            if (wr && ix >= 0) begin
                v = ma[ix];
                ma[ix] = hi ? {wd[31:0], v[31:0]} : {v[63:32], wd[31:0]};
            end
        end else begin
            mb[1] = mb[1] + 64'(tk); mb[2] = mb[2] + 64'(ret);
            if (wr && ix >= 0) mb[ix] = wd;
        end
        @(negedge clk);
        if (which == 0) begin
            chk(rdat_a == exp_d[31:0], {req, " rdata32"}, {32'h0, rdat_a}, exp_d);
            chk(il_a == exp_il, {req, " illegal32"}, {63'h0, il_a}, {63'h0, exp_il});
        end else begin
            chk(rdat_b == exp_d, {req, " rdata64"}, rdat_b, exp_d);
            chk(il_b == exp_il, {req, " illegal64"}, {63'h0, il_b}, {63'h0, exp_il});
        end
    endtask

    // {rd, wr, addr[11:0], wdata[31:0], retire, tick}
    localparam int NV = 14;
    localparam logic [47:0] VEC [NV] = '{
        {1'b1, 1'b0, 12'hC00, 32'h0,        1'b0, 1'b0},  // R2 cycle read
        {1'b1, 1'b0, 12'hC01, 32'h0,        1'b0, 1'b1},  // R3 read with tick
        {1'b1, 1'b0, 12'hC01, 32'h0,        1'b0, 1'b0},  // R3 tick visible
        {1'b1, 1'b0, 12'hC02, 32'h0,        1'b1, 1'b0},  // R5 read during retire
        {1'b1, 1'b0, 12'hC02, 32'h0,        1'b0, 1'b0},  // R4 retire visible
        {1'b0, 1'b1, 12'hC02, 32'h5,        1'b1, 1'b0},  // R8 write with retire
        {1'b1, 1'b0, 12'hC02, 32'h0,        1'b0, 1'b0},  // R8 reads 5
        {1'b1, 1'b0, 12'hC82, 32'h0,        1'b0, 1'b0},  // R6 high half
        {1'b1, 1'b0, 12'hC03, 32'h0,        1'b0, 1'b0},  // R9 unmapped read
        {1'b0, 1'b1, 12'hC05, 32'hDEAD,     1'b0, 1'b0},  // R9 unmapped write
        {1'b0, 1'b0, 12'hC00, 32'h0,        1'b0, 1'b1},  // R11 idle
        {1'b1, 1'b0, 12'hC81, 32'h0,        1'b0, 1'b0},  // R6 time high
        {1'b1, 1'b1, 12'hC80, 32'hA,        1'b0, 1'b0},  // R6 read old + write high
        {1'b1, 1'b0, 12'hC80, 32'h0,        1'b0, 1'b0}   // R6 high written
    };

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] h1, l1, h2;
        t_a = 0; r_a = 0; rd_a = 0; wr_a = 0; ad_a = '0; wd_a = '0;
        t_b = 0; r_b = 0; rd_b = 0; wr_b = 0; ad_b = '0; wd_b = '0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs clear while in reset
        chk(rdat_a == '0 && !il_a, "R1 reset outputs", {32'h0, rdat_a}, 64'h0);
        rst = 0;

        for (int i = 0; i < NV; i++)
            step(0, VEC[i][47], VEC[i][46], VEC[i][45:34], {32'h0, VEC[i][33:2]},
                 VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));

        // R8: high write with retire keeps the incremented low half
        step(0, 0, 1, 12'hC02, 64'hFFFF_FFFF, 0, 0, "R8 preset low");
        step(0, 0, 1, 12'hC82, 64'h7, 1, 0, "R8 high write with retire");
        step(0, 1, 0, 12'hC02, 64'h0, 0, 0, "R8 low after carry");
        chk(rdat_a == 32'h0, "R8 low is zero", {32'h0, rdat_a}, 64'h0);
        step(0, 1, 0, 12'hC82, 64'h0, 0, 0, "R8 high holds written");
        chk(rdat_a == 32'h7, "R8 high is seven", {32'h0, rdat_a}, 64'h7);

        // R10: carry from bit 31 between the two high reads
        step(0, 0, 1, 12'hC80, 64'h0, 0, 0, "R10 clear high");
        step(0, 0, 1, 12'hC00, 64'hFFFF_FFFE, 0, 0, "R10 preset low");
        step(0, 1, 0, 12'hC80, 64'h0, 0, 0, "R10 high1"); h1 = rdat_a;
        step(0, 1, 0, 12'hC00, 64'h0, 0, 0, "R10 low");   l1 = rdat_a;
        step(0, 1, 0, 12'hC80, 64'h0, 0, 0, "R10 high2"); h2 = rdat_a;
        chk(h1 == 32'h0 && l1 == 32'hFFFF_FFFF && h2 == 32'h1, "R10 carry seen",
            {h1, h2}, {32'h0, 32'h1});
        step(0, 1, 0, 12'hC80, 64'h0, 0, 0, "R10 retry high");
        step(0, 1, 0, 12'hC00, 64'h0, 0, 0, "R10 retry low");
        step(0, 1, 0, 12'hC80, 64'h0, 0, 0, "R10 retry high2");

        // R7: 64-bit configuration
        step(1, 1, 0, 12'hC00, 64'h0, 0, 0, "R7 full cycle read");
        step(1, 1, 0, 12'hC80, 64'h0, 0, 0, "R7 high illegal");
        step(1, 0, 1, 12'hC02, 64'h1_2345_6789, 1, 0, "R7 full write");
        step(1, 1, 0, 12'hC02, 64'h0, 0, 1, "R7 full readback");
        chk(rdat_b == 64'h1_2345_6789, "R7 readback value", rdat_b, 64'h1_2345_6789);
        step(1, 1, 0, 12'hC01, 64'h0, 0, 0, "R3 64 time");

        // R1: mid-run reset clears counters
        rst = 1; @(negedge clk); @(negedge clk); rst = 0;
        model_reset();
        step(0, 1, 0, 12'hC02, 64'h0, 0, 0, "R1 instret cleared");
        step(1, 1, 0, 12'hC00, 64'h0, 0, 0, "R1 cycle cleared 64");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule